// File: doc/BRIEF.md
# Dispatch Group Hazard Checker

This block sits beside a superscalar front end and decides, one candidate at a time, whether an instruction may still join the dispatch group being assembled. A group has five slots. The candidate is presented as an 8-bit opcode and a valid strobe. A small internal lookup turns the opcode into an instruction class. The hazard answer is combinational, so the front end can act on it in the same cycle.

When the front end asserts `issue` for a candidate that carries no hazard, the block records it. It counts the instruction against the per-group quota of the matching unit, sets a single-use flag where the unit allows only one, and advances the slot position. A branch closes the group. An explicit end-of-group strobe or a reset also starts a fresh group. A candidate refused for a hazard is expected to come back in the next group.

Top module: `dispatch_group_checker`

## Requirements
- R1: Opcode map (hex). 01 and 02 are fixed-point. 03, 04, 05 and 06 are the signed and unsigned word and doubleword divides, which are lead-only fixed-point. 10 and 11 are loads. 12 and 13 are stores. 20 and 21 are floating-point. 30 (condition-field move), 31 (whole condition register read) and 32 (single-field read) are condition-register. 40 to 43 (link read/write, count read/write) are special-register. 50 is vector-ALU. 58 is vector-permute. 60, 61 and 62 are branches. Any other code with `cand_valid` high raises both `class_err` and `hazard`.
- R2: A group holds at most two fixed-point operations, and lead-only ones count toward that limit. A third is a hazard.
- R3: Loads and stores share one per-group quota of two. Floating-point has its own quota of two.
- R4: Condition-register, special-register, vector-ALU and vector-permute operations are each limited to one per group.
- R5: Condition-register, special-register and lead-only fixed-point candidates are hazards unless `slot_idx` is 0.
- R6: When `slot_idx` is 4, every non-branch candidate is a hazard. A branch there is accepted.
- R7: An accepted branch closes the group. In the next cycle the candidate is judged against an empty group with `slot_idx` 0.
- R8: While `end_group` is high, the candidate in that cycle is judged against an empty group (`slot_idx` 0). An issue in that cycle becomes the first member of the new group.
- R9: Reset empties the group. All counts and flags are cleared and `slot_idx` is 0.
- R10: `issue` while `hazard` is high, or while `cand_valid` is low, leaves the group state unchanged.
- R11: A class is checked only against its own unit quota and the slot rules. A full quota in one unit never blocks another unit.
- R12: With `cand_valid` low, `hazard` and `class_err` are low. `slot_idx` always gives the slot the next accepted instruction would take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | Candidate opcode is present |
| cand_op | input | 8 | Candidate opcode |
| issue | input | 1 | Front end dispatches the candidate this cycle |
| end_group | input | 1 | Force a new group starting this cycle |
| hazard | output | 1 | Candidate cannot join the current group |
| class_err | output | 1 | Candidate opcode is not in the map |
| slot_idx | output | 3 | Slot the next accepted instruction occupies |

## Verification
`hazard`, `class_err` and `slot_idx` are combinational in the current candidate, `end_group` and the stored group state. They are therefore due in the same cycle as the stimulus, and the bench reads them one time unit after it drives inputs at the falling edge. The effect of an accepted issue shows up only after the next rising edge. The bench tests it through the hazard and slot answers for the following vector, never in the cycle of the issue itself. The table is ordered so that each refused or ignored issue is followed by a vector whose expected slot shows that no state moved.

// File: rtl/dgh_pkg.sv
package dgh_pkg;

  localparam int OP_W   = 8;
  localparam int CNT_W  = 3;
  localparam int SLOT_W = 3;

  typedef enum logic [3:0] {
    CL_FX     = 4'd0,
    CL_FXLEAD = 4'd1,
    CL_LOAD   = 4'd2,
    CL_STORE  = 4'd3,
    CL_FP     = 4'd4,
    CL_CR     = 4'd5,
    CL_SPR    = 4'd6,
    CL_VALU   = 4'd7,
    CL_VPERM  = 4'd8,
    CL_BR     = 4'd9,
    CL_BAD    = 4'd15
  } cls_e;

  typedef struct packed {
    logic [SLOT_W-1:0] used;
    logic [CNT_W-1:0]  fx_n;
    logic [CNT_W-1:0]  ls_n;
    logic [CNT_W-1:0]  fp_n;
    logic              cr_f;
    logic              spr_f;
    logic              valu_f;
    logic              vperm_f;
  } grp_t;

  // Opcode to class lookup
  function automatic cls_e decode_op(input logic [OP_W-1:0] op);
    case (op)
      8'h01, 8'h02:                return CL_FX;
      8'h03, 8'h04, 8'h05, 8'h06:  return CL_FXLEAD;
      8'h10, 8'h11:                return CL_LOAD;
      8'h12, 8'h13:                return CL_STORE;
      8'h20, 8'h21:                return CL_FP;
      8'h30, 8'h31, 8'h32:         return CL_CR;
      8'h40, 8'h41, 8'h42, 8'h43:  return CL_SPR;
      8'h50:                       return CL_VALU;
      8'h58:                       return CL_VPERM;
      8'h60, 8'h61, 8'h62:         return CL_BR;
      default:                     return CL_BAD;
    endcase
  endfunction

  // Classes that may only occupy the first slot
  function automatic logic lead_only(input cls_e c);
    return (c == CL_FXLEAD) || (c == CL_CR) || (c == CL_SPR);
  endfunction

  function automatic grp_t grp_clear();
    grp_t g;
    g = '0;
    return g;
  endfunction

  // Quota reached for a counted unit
  function automatic logic at_limit(input logic [CNT_W-1:0] n, input int lim);
    return int'(n) >= lim;
  endfunction

  // Group state after accepting one instruction of class c
  function automatic grp_t grp_add(input grp_t g, input cls_e c, input int slots);
    grp_t r;
    r = g;
    case (c)
      CL_FX, CL_FXLEAD:  r.fx_n    = g.fx_n + CNT_W'(1);
      CL_LOAD, CL_STORE: r.ls_n    = g.ls_n + CNT_W'(1);
      CL_FP:             r.fp_n    = g.fp_n + CNT_W'(1);
      CL_CR:             r.cr_f    = 1'b1;
      CL_SPR:            r.spr_f   = 1'b1;
      CL_VALU:           r.valu_f  = 1'b1;
      CL_VPERM:          r.vperm_f = 1'b1;
      default:           r = g;
    endcase
    if (c == CL_BR) r.used = SLOT_W'(slots);
    else            r.used = g.used + SLOT_W'(1);
    return r;
  endfunction

endpackage

// File: rtl/dgh_decode.sv
module dgh_decode
  import dgh_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output cls_e            cls,
  output logic            known
);

  always_comb begin
    cls   = decode_op(op);
    known = (cls != CL_BAD);
  end

endmodule

// File: rtl/dgh_group_state.sv
module dgh_group_state
  import dgh_pkg::*;
#(
  parameter int SLOTS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic end_group,
  input  logic take,
  input  cls_e take_cls,
  output grp_t live,
  output logic fresh
);

  grp_t state_q;
  grp_t state_d;

  // A closed group or an explicit end presents an empty group at once
  always_comb begin
    fresh = end_group || (int'(state_q.used) >= SLOTS);
    live  = fresh ? grp_clear() : state_q;
    state_d = take ? grp_add(live, take_cls, SLOTS) : live;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= grp_clear();
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dgh_hazard_eval.sv
module dgh_hazard_eval
  import dgh_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int FX_MAX = 2,
  parameter int LS_MAX = 2,
  parameter int FP_MAX = 2
) (
  input  cls_e cls,
  input  grp_t live,
  output logic quota_hz,
  output logic lead_hz,
  output logic tail_hz
);

  localparam int TAIL_SLOT = SLOTS - 1;

  // Each class checks only its own unit
  always_comb begin
    case (cls)
      CL_FX, CL_FXLEAD:  quota_hz = at_limit(live.fx_n, FX_MAX);
      CL_LOAD, CL_STORE: quota_hz = at_limit(live.ls_n, LS_MAX);
      CL_FP:             quota_hz = at_limit(live.fp_n, FP_MAX);
      CL_CR:             quota_hz = live.cr_f;
      CL_SPR:            quota_hz = live.spr_f;
      CL_VALU:           quota_hz = live.valu_f;
      CL_VPERM:          quota_hz = live.vperm_f;
      default:           quota_hz = 1'b0;
    endcase
    lead_hz = lead_only(cls) && (live.used != '0);
    tail_hz = (int'(live.used) == TAIL_SLOT) && (cls != CL_BR);
  end

endmodule

// File: rtl/dispatch_group_checker.sv
module dispatch_group_checker
  import dgh_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int FX_MAX = 2,
  parameter int LS_MAX = 2,
  parameter int FP_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [OP_W-1:0]   cand_op,
  input  logic              issue,
  input  logic              end_group,
  output logic              hazard,
  output logic              class_err,
  output logic [SLOT_W-1:0] slot_idx
);

  cls_e cand_cls;
  logic cand_known;
  grp_t live;
  logic fresh;
  logic quota_hz;
  logic lead_hz;
  logic tail_hz;
  logic issue_ok;

  dgh_decode u_dec (
    .op    (cand_op),
    .cls   (cand_cls),
    .known (cand_known)
  );

  dgh_hazard_eval #(
    .SLOTS  (SLOTS),
    .FX_MAX (FX_MAX),
    .LS_MAX (LS_MAX),
    .FP_MAX (FP_MAX)
  ) u_eval (
    .cls      (cand_cls),
    .live     (live),
    .quota_hz (quota_hz),
    .lead_hz  (lead_hz),
    .tail_hz  (tail_hz)
  );

  always_comb begin
    class_err = cand_valid && !cand_known;
    hazard    = cand_valid && (!cand_known || quota_hz || lead_hz || tail_hz);
    issue_ok  = issue && cand_valid && !hazard;
    slot_idx  = live.used;
  end

  dgh_group_state #(
    .SLOTS (SLOTS)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_group (end_group),
    .take      (issue_ok),
    .take_cls  (cand_cls),
    .live      (live),
    .fresh     (fresh)
  );

endmodule

// File: rtl/dgh_checker.sv
module dgh_checker
  import dgh_pkg::*;
#(
  parameter int SLOTS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cand_valid,
  input logic              issue,
  input logic              end_group,
  input logic              hazard,
  input logic              class_err,
  input logic [SLOT_W-1:0] slot_idx,
  input cls_e              cand_cls,
  input logic              issue_ok
);

  localparam logic [SLOT_W-1:0] TAIL = SLOT_W'(SLOTS - 1);

  // R1
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    class_err |-> hazard);

  // R5
  lead_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && slot_idx != '0 &&
     (cand_cls == CL_FXLEAD || cand_cls == CL_CR || cand_cls == CL_SPR)) |-> hazard);

  // R6
  tail_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && slot_idx == TAIL && cand_cls != CL_BR) |-> hazard);

  // R7
  branch_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && cand_cls == CL_BR) |=> (slot_idx == '0));

  // R8
  end_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_group |-> (slot_idx == '0));

  // R10
  ignored_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !issue_ok) |=> (end_group || slot_idx == $past(slot_idx)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> (!hazard && !class_err));

  // R12
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && cand_cls != CL_BR) |=> (end_group || slot_idx == $past(slot_idx) + SLOT_W'(1)));

endmodule

bind dispatch_group_checker dgh_checker #(.SLOTS(SLOTS)) u_dgh_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_valid (cand_valid),
  .issue      (issue),
  .end_group  (end_group),
  .hazard     (hazard),
  .class_err  (class_err),
  .slot_idx   (slot_idx),
  .cand_cls   (cand_cls),
  .issue_ok   (issue_ok)
);

// File: tb/tb_dispatch_group_checker.sv
module tb_dispatch_group_checker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cand_valid = 1'b0;
  logic [7:0] cand_op = 8'h00;
  logic       issue = 1'b0;
  logic       end_group = 1'b0;
  logic       hazard;
  logic       class_err;
  logic [2:0] slot_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dispatch_group_checker dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_op    (cand_op),
    .issue      (issue),
    .end_group  (end_group),
    .hazard     (hazard),
    .class_err  (class_err),
    .slot_idx   (slot_idx)
  );

  // Vector: req[23:20] end[19] issue[18] valid[17] op[16:9] hz[8] err[7] slot[6:4]
  function automatic logic [23:0] mk(int r, bit e, bit i, bit v, logic [7:0] op,
                                     bit hz, bit err, int slot);
    return {4'(r), e, i, v, op, hz, err, 3'(slot), 4'd0};
  endfunction

  localparam int NV = 33;
  localparam logic [23:0] VEC [NV] = '{
    mk(5,  0,1,1,8'h30, 0,0,0),  // R5 condition op first in group
    mk(2,  0,1,1,8'h01, 0,0,1),  // R2
    mk(4,  0,1,1,8'h31, 1,0,2),  // R4 second condition op refused
    mk(2,  0,1,1,8'h02, 0,0,2),  // R2 second fixed-point
    mk(2,  0,1,1,8'h01, 1,0,3),  // R2 third fixed-point refused
    mk(3,  0,1,1,8'h10, 0,0,3),  // R3
    mk(6,  0,1,1,8'h12, 1,0,4),  // R6 store in last slot refused
    mk(7,  0,1,1,8'h60, 0,0,4),  // R7 branch in last slot
    mk(7,  0,1,1,8'h03, 0,0,0),  // R7 fresh group after branch
    mk(5,  0,1,1,8'h04, 1,0,1),  // R5 divide not in slot 0
    mk(2,  0,1,1,8'h01, 0,0,1),  // R2 lead divide counted
    mk(2,  0,1,1,8'h02, 1,0,2),  // R2 quota reached with a divide
    mk(11, 0,1,1,8'h20, 0,0,2),  // R11 fp unaffected by fx quota
    mk(3,  0,1,1,8'h21, 0,0,3),  // R3
    mk(8,  1,1,1,8'h40, 0,0,0),  // R8 end_group with issue
    mk(4,  0,1,1,8'h41, 1,0,1),  // R4 special register once
    mk(4,  0,1,1,8'h50, 0,0,1),  // R4
    mk(4,  0,1,1,8'h50, 1,0,2),  // R4 vector ALU once
    mk(4,  0,1,1,8'h58, 0,0,2),  // R4
    mk(4,  0,1,1,8'h58, 1,0,3),  // R4 vector permute once
    mk(1,  0,1,1,8'h00, 1,1,3),  // R1 unknown opcode
    mk(10, 0,1,0,8'h01, 0,0,3),  // R10 issue without valid
    mk(10, 0,1,1,8'h11, 0,0,3),  // R10 slot unchanged by ignored issues
    mk(8,  1,0,0,8'h00, 0,0,0),  // R8 end_group alone
    mk(3,  0,1,1,8'h10, 0,0,0),  // R3
    mk(3,  0,1,1,8'h13, 0,0,1),  // R3 store shares count
    mk(3,  0,1,1,8'h11, 1,0,2),  // R3 shared quota reached
    mk(11, 0,1,1,8'h20, 0,0,2),  // R11 fp unaffected by load/store quota
    mk(7,  0,1,1,8'h61, 0,0,3),  // R7 branch mid-group
    mk(4,  0,1,1,8'h32, 0,0,0),  // R4 flag cleared in new group
    mk(5,  0,1,1,8'h42, 1,0,1),  // R5 special register not first
    mk(7,  0,1,1,8'h62, 0,0,1),  // R7 early branch
    mk(5,  0,0,1,8'h05, 0,0,0)   // R5 lead divide at fresh slot 0
  };

  function automatic bit ref_known(logic [7:0] op);
    return (op >= 8'h01 && op <= 8'h06) || (op >= 8'h10 && op <= 8'h13) ||
           op == 8'h20 || op == 8'h21 || (op >= 8'h30 && op <= 8'h32) ||
           (op >= 8'h40 && op <= 8'h43) || op == 8'h50 || op == 8'h58 ||
           (op >= 8'h60 && op <= 8'h62);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic drive(bit e, bit i, bit v, logic [7:0] op);
    @(negedge clk);
    end_group  = e;
    issue      = i;
    cand_valid = v;
    cand_op    = op;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9", "slot after reset", int'(slot_idx), 0);
    chk("R12", "hazard idle", int'(hazard), 0);
    chk("R12", "class_err idle", int'(class_err), 0);

    for (int k = 0; k < NV; k++) begin
      logic [23:0] w;
      string tag;
      w = VEC[k];
      tag = $sformatf("R%0d vec%0d", int'(w[23:20]), k);
      drive(w[19], w[18], w[17], w[16:9]);
      chk(tag, "hazard", int'(hazard), int'(w[8]));
      chk(tag, "class_err", int'(class_err), int'(w[7]));
      chk(tag, "slot", int'(slot_idx), int'(w[6:4]));
    end

    // R9 reset in the middle of a group
    drive(0, 1, 1, 8'h30);
    drive(0, 1, 1, 8'h01);
    drive(0, 0, 1, 8'h31);
    chk("R9", "slot before reset", int'(slot_idx), 2);
    @(negedge clk);
    rst_n = 1'b0;
    issue = 1'b0;
    cand_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 1, 8'h31);
    chk("R9", "slot after mid reset", int'(slot_idx), 0);
    chk("R9", "condition flag cleared", int'(hazard), 0);

    // R1 opcode sweep against an empty group
    for (int op = 0; op < 256; op++) begin
      drive(0, 0, 1, 8'(op));
      chk("R1", $sformatf("class_err op %0h", op), int'(class_err), int'(!ref_known(8'(op))));
      chk("R1", $sformatf("hazard op %0h", op), int'(hazard), int'(!ref_known(8'(op))));
    end

    drive(0, 0, 0, 8'h00);
    finish_run();
  end

endmodule